// File: doc/BRIEF.md
# Squaring CIC Decimation Front End

This block is the first stage of an envelope-recovery chain for radio interferometric ranging. Two carriers close in frequency arrive mixed down to an intermediate frequency. The block multiplies every incoming signed 12-bit sample by itself. Squaring turns the difference between the two carriers into a real low-frequency component, together with a DC term and components near the carrier sums. The squared stream then enters a two-stage cascaded integrator-comb decimator. The decimator keeps one result for every sixteen input samples and removes most of the high-frequency products before the narrower filters that follow.

Input samples arrive with a one-cycle valid strobe, nominally once every twenty clocks (1 MSPS on a 20 MHz clock). The block also accepts back-to-back samples. Each result carries a one-cycle valid strobe. The filter's DC gain of 256 is taken out by dropping the eight low bits, so a constant input `x` settles to an output of exactly `x*x`. The integrators are allowed to wrap. Their width is chosen so that the comb differences still come out exact.

Top module: `sq_cic_decimator`

## Requirements
- R1: A synchronous reset clears the squarer, every integrator and comb delay, the decimation count, `outData` (to 0) and `outValid` (to 0). The first result after reset treats all earlier samples as zero.
- R2: `inSample` is read as signed two's complement, so -2048 squares to 4194304 and 2047 squares to 4190209. After the filter settles, a constant input `x` gives `outData` equal to `x*x`.
- R3: With the squared samples counted from 0 since reset, the result produced on squared sample n (n = 16k+15) is floor(sum over j=0..30 of w(j)*sq(n-j) / 256). Here w(j)=j+1 for j<16, w(j)=31-j otherwise, and sq of a negative index is 0.
- R4: Exactly one result is produced for every 16 valid input samples. `outValid` is high for a single clock, 3 clocks after the clock edge that samples the 16th valid input.
- R5: When `inValid` is low, the value on `inSample` has no effect on any later result.
- R6: `outData` is the 31-bit comb result with its 8 low bits dropped (truncation toward zero), and it never exceeds 4194304. Between results it holds its value.
- R7: Integrator wraparound under a sustained full-scale input does not corrupt the results. The full-scale steady-state output stays 4194304.
- R8: Results do not depend on the spacing of valid samples. Back-to-back strobes and strobes many clocks apart give the same values for the same sample sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe marking a new input sample |
| inSample | input | 12 | Signed IF sample |
| outValid | output | 1 | One-clock strobe marking a new result |
| outData | output | 23 | Gain-compensated decimated squared signal |

## Verification
Some properties are checked on every clock by assertions. `outValid` follows the sixteenth valid input by exactly three clocks and lasts a single clock. `outData` only changes when a result is delivered and never goes above the full-scale square. Reset leaves the output quiet. The arithmetic itself can only be shown by the bench scenarios, which compare each result against the triangular-kernel sum: an isolated impulse, sustained full-scale input that drives the integrators through wraparound, small values that expose truncation, and sparse samples with junk between strobes. The bench also applies a reset in the middle of a block of samples.

// File: rtl/sqcic_pkg.sv
package sqcic_pkg;

  // Strobes issued by the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic sqLoad;   // capture the square of the current input
    logic integEn;  // advance the integrator chain by one squared sample
    logic combEn;   // run the comb chain and load the output register
  } cicStrobe_t;

endpackage

// File: rtl/sqcic_ctrl.sv
module sqcic_ctrl
  import sqcic_pkg::*;
#(
  parameter int RATE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output cicStrobe_t strobe,
  output logic       outValid
);

  localparam int CNT_W = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             integEnQ;
  logic             combEnQ;
  logic             outValidQ;

  // Squarer register loads in the same cycle the sample is offered;
  // integrators advance one clock later; combs one clock after the
  // sixteenth integrator step; the output strobe one clock after that.
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt  <= '0;
      integEnQ  <= 1'b0;
      combEnQ   <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      integEnQ  <= inValid;
      combEnQ   <= integEnQ && (phaseCnt == LAST);
      outValidQ <= combEnQ;
      if (integEnQ) begin
        phaseCnt <= (phaseCnt == LAST) ? '0 : phaseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.sqLoad  = inValid;
    strobe.integEn = integEnQ;
    strobe.combEn  = combEnQ;
  end

  assign outValid = outValidQ;

endmodule

// File: rtl/sqcic_datapath.sv
module sqcic_datapath
  import sqcic_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int RATE   = 16,
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cicStrobe_t           strobe,
  input  logic [IN_W-1:0]      inSample,
  output logic [2*IN_W-2:0]    outData
);

  localparam int SQ_W  = 2 * IN_W - 1;
  localparam int SHIFT = STAGES * $clog2(RATE);
  localparam int ACC_W = SQ_W + SHIFT;

  // ---------------- squarer ----------------
  logic signed [IN_W-1:0] sampleS;
  logic        [SQ_W-1:0] sqNext;
  logic        [SQ_W-1:0] sqReg;

  assign sampleS = $signed(inSample);
  assign sqNext  = SQ_W'(sampleS * sampleS);

  always_ff @(posedge clk) begin
    if (rst) begin
      sqReg <= '0;
    end else if (strobe.sqLoad) begin
      sqReg <= sqNext;
    end
  end

  // ---------------- integrator chain ----------------
  logic [ACC_W-1:0] integQ [STAGES];
  logic [ACC_W-1:0] integD [STAGES];

  always_comb begin
    logic [ACC_W-1:0] runSum;
    runSum = {{SHIFT{1'b0}}, sqReg};
    for (int i = 0; i < STAGES; i++) begin
      runSum    = integQ[i] + runSum;
      integD[i] = runSum;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_integ
    always_ff @(posedge clk) begin
      if (rst) begin
        integQ[g] <= '0;
      end else if (strobe.integEn) begin
        integQ[g] <= integD[g];
      end
    end
  end

  // ---------------- comb chain ----------------
  logic [ACC_W-1:0] combDly [STAGES];
  logic [ACC_W-1:0] combIn  [STAGES];
  logic [ACC_W-1:0] combOut;

  always_comb begin
    logic [ACC_W-1:0] diff;
    diff = integQ[STAGES-1];
    for (int i = 0; i < STAGES; i++) begin
      combIn[i] = diff;
      diff      = diff - combDly[i];
    end
    combOut = diff;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    always_ff @(posedge clk) begin
      if (rst) begin
        combDly[g] <= '0;
      end else if (strobe.combEn) begin
        combDly[g] <= combIn[g];
      end
    end
  end

  // ---------------- gain compensation and output ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
    end else if (strobe.combEn) begin
      outData <= combOut[ACC_W-1:SHIFT];
    end
  end

endmodule

// File: rtl/sq_cic_decimator.sv
module sq_cic_decimator
  import sqcic_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int RATE   = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inSample,
  output logic              outValid,
  output logic [2*IN_W-2:0] outData
);

  cicStrobe_t strobe;

  sqcic_ctrl #(
    .RATE (RATE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sqcic_datapath #(
    .IN_W   (IN_W),
    .RATE   (RATE),
    .STAGES (STAGES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inSample (inSample),
    .outData  (outData)
  );

endmodule

// File: rtl/sqcic_checker.sv
module sqcic_checker #(
  parameter int IN_W = 12,
  parameter int RATE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [2*IN_W-2:0] outData
);

  localparam int CNT_W = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [2*IN_W-2:0] FULL_SQ = (2*IN_W-1)'(1) << (2*IN_W-2);

  logic [CNT_W-1:0] seenCnt;
  logic             lastOfBlock;

  assign lastOfBlock = !rst && inValid && (seenCnt == CNT_W'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seenCnt <= '0;
    end else if (inValid) begin
      seenCnt <= seenCnt + 1'b1;
    end
  end

  // R4: a result appears exactly three clocks after each sixteenth valid input
  a_r4_cadence: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(lastOfBlock, 3));

  // R4: the result strobe lasts one clock
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6: the output holds between results
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData));

  // R6: the output never exceeds the full-scale square
  a_r6_bound: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData <= FULL_SQ));

  // R1: after a reset edge the output is quiet and cleared
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && outData == '0));

endmodule

bind sq_cic_decimator sqcic_checker #(
  .IN_W (IN_W),
  .RATE (RATE)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/tb_sq_cic_decimator.sv
`timescale 1ns/1ps
module tb_sq_cic_decimator;

  localparam int IN_W = 12;
  localparam int RATE = 16;
  localparam int KLEN = 2 * RATE - 1;
  localparam int OUT_W = 2 * IN_W - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  inSample = '0;
  logic             outValid;
  logic [OUT_W-1:0] outData;

  sq_cic_decimator dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inSample (inSample),
    .outValid (outValid),
    .outData  (outData)
  );

  always #4 clk = ~clk;  // 125 MHz

  int     cyc = 0;
  int     testsRun = 0;
  int     testsFailed = 0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint value;
    int     dueCycle;
    string  tag;
  } expItem_t;

  expItem_t expQ[$];
  longint   hist[$];

  task automatic check(input string req, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint weight(input int j);
    return (j < RATE) ? longint'(j + 1) : longint'(KLEN - j);
  endfunction

  // Reference: triangular-kernel sum over the squared history, then drop 8 bits.
  function automatic longint model(input int n);
    longint acc = 0;
    for (int j = 0; j < KLEN; j++) begin
      if (n - j >= 0) acc += weight(j) * hist[n - j];
    end
    return acc / 256;
  endfunction

  // Driver: offers one sample, records expectations, then idles with junk on the bus.
  task automatic sendSample(input int value, input int gap, input string tag);
    inValid  = 1'b1;
    inSample = IN_W'(value);
    hist.push_back(longint'(value) * longint'(value));
    if (hist.size() % RATE == 0) begin
      expItem_t it;
      it.value    = model(hist.size() - 1);
      it.dueCycle = cyc + 3;
      it.tag      = tag;
      expQ.push_back(it);
    end
    @(negedge clk);
    for (int k = 0; k < gap; k++) begin
      inValid  = 1'b0;
      inSample = IN_W'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    expQ.delete();
    hist.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: pops expected results as the design produces them.
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check("R4 unexpected result", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, longint'(outData), it.value);
        check("R4 result timing", longint'(cyc), longint'(it.dueCycle));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet output in and right after reset
    check("R1 outValid in reset", longint'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outData after reset", longint'(outData), 0);
    check("R1 outValid after reset", longint'(outValid), 0);

    // R3: isolated impulse on sample 5 reaches two results with weights 11 and 5
    for (int i = 0; i < 48; i++) sendSample((i == 5) ? 100 : 0, 1, "R3 impulse");
    idle(6);

    // R2 / R7: sustained full-scale negative input, back to back, wraps integrators
    applyReset();
    for (int i = 0; i < 96; i++) sendSample(-2048, 0, "R7 full-scale wrap");
    idle(6);

    // R2: positive extreme, steady state equals 2047*2047
    for (int i = 0; i < 64; i++) sendSample(2047, 0, "R2 signed square");
    idle(6);

    // R6: small values expose truncation of the 8 dropped bits
    applyReset();
    for (int i = 0; i < 48; i++) sendSample((i % 3) + 1, 2, "R6 truncation");
    idle(6);

    // R5 / R8: sparse strobes with junk between them, nominal 20-clock spacing
    applyReset();
    for (int i = 0; i < 48; i++) sendSample(((i * 37) % 4096) - 2048, 19, "R5 junk ignored");
    idle(6);

    // R8: same sequence back to back gives the same values
    applyReset();
    for (int i = 0; i < 48; i++) sendSample(((i * 37) % 4096) - 2048, 0, "R8 spacing");
    idle(6);

    // R1: reset in the middle of a block discards the partial block
    for (int i = 0; i < 8; i++) sendSample(1500, 0, "R1 pre-reset");
    applyReset();
    @(negedge clk);
    check("R1 outData cleared mid-run", longint'(outData), 0);
    for (int i = 0; i < 32; i++) sendSample(1000, 1, "R1 history cleared");
    idle(8);

    check("R4 all results delivered", longint'(expQ.size()), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule